// File: doc/BRIEF.md
# Chained Descriptor Transmit DMA

This block moves outgoing frames from memory to a byte stream. It works without a processor in the loop. Software builds a list of 8-byte descriptors in memory and points the block at a table of queue heads. It then raises a request bit. The engine reads the head entry for its single queue and follows any link entries. For each frame entry it streams the referenced buffer out one byte at a time, then rewrites the entry so that software can see the frame has gone.

Each descriptor holds two 32-bit words. The first is a control word, with a 4-bit kind code in bits 31:28 and a byte count in bits 11:0. The second word is a buffer or jump address. The engine stops at an entry that holds nothing to send and drops the request bit. On the next request it resumes from that same entry. A ring is therefore built by ending the list with a link back to its start.

Top module: `txdesc_dma`

## Requirements
- R1: After reset the engine is idle. No memory request and no stream byte is presented, and the mode, status and request registers read zero.
- R2: Register index 0 holds the mode: writing bit 0 selects configuration mode and writing bit 1 selects running mode. Status at index 3 reports configuration mode in bit 1 and running mode in bit 0. Outside running mode a raised request starts no memory access and stays set.
- R3: The first start after reset, or after configuration mode, reads the queue head from the table entry at the base address held at index 1, plus eight times the queue index (default 0).
- R4: Kind 0x7 sends a frame. The count from bits 11:0 gives the number of bytes, read from the pointer word's address with words unpacked lowest byte first. Last is raised on the final byte only.
- R5: A frame entry with count zero sends no byte and is still written back.
- R6: Kind 0x9 makes the engine continue fetching at the address held in its pointer word.
- R7: After a frame is sent, its control word is rewritten with kind 0x3 in bits 31:28 and all other bits kept. The pointer word is not written. The engine then moves 8 bytes on.
- R8: An entry of kind 0x3, 0xA or any other unlisted code stops the engine. That entry is not written, the request bit at index 2 bit 0 clears, and the next request resumes at that entry. Writing 1 to the bit sets it and writing 0 leaves it unchanged.
- R9: A memory request holds its address, direction and write data until the cycle in which grant is seen. Read data is taken in that same cycle.
- R10: A presented stream byte keeps its data and last flag until accepted by ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index: 0 mode, 1 base, 2 request, 3 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the indexed register |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Transfer is a write |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Grant; completes the transfer this cycle |
| mem_rdata | input | 32 | Read data, valid in the grant cycle |
| tx_valid | output | 1 | Stream byte present |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Sink accepts the byte |

## Verification
The memory-hold property assumes that the mode is not taken out of running mode while a descriptor fetch is waiting for grant. At that point the engine withdraws the request on purpose. The stimulus changes the mode only while the engine is idle. It also assumes buffer and descriptor addresses are word aligned, and every address in the stimulus is a multiple of four. Grant and ready are throttled in fixed repeating patterns, so that the hold properties see stalls on both interfaces.

// File: rtl/txd_pkg.sv
package txd_pkg;
   localparam int DESC_BYTES = 8;
   localparam int WORD_BYTES = 4;

   localparam logic [1:0] RIDX_MODE   = 2'd0;
   localparam logic [1:0] RIDX_BASE   = 2'd1;
   localparam logic [1:0] RIDX_REQ    = 2'd2;
   localparam logic [1:0] RIDX_STATUS = 2'd3;

   localparam logic [3:0] KIND_EMPTY = 4'h3;
   localparam logic [3:0] KIND_FRAME = 4'h7;
   localparam logic [3:0] KIND_LINK  = 4'h9;
   localparam logic [3:0] KIND_END   = 4'hA;

   typedef enum logic [2:0] {
      W_IDLE,
      W_CTRL,
      W_PTR,
      W_DECIDE,
      W_DATA,
      W_WBACK
   } walk_st_e;
endpackage

// File: rtl/txd_regs.sv
module txd_regs
   import txd_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic [1:0]    reg_addr,
   input  logic [31:0]   reg_wdata,
   output logic [31:0]   reg_rdata,
   input  logic          clr_req,
   output logic          cfg_mode,
   output logic          op_mode,
   output logic [AW-1:0] base_addr,
   output logic          tx_req
);
   logic [1:0] mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= '0;
         base_addr <= '0;
         tx_req    <= 1'b0;
      end else begin
         if (reg_we && reg_addr == RIDX_MODE) mode_q <= reg_wdata[1:0];
         if (reg_we && reg_addr == RIDX_BASE) base_addr <= reg_wdata[AW-1:0];
         if (reg_we && reg_addr == RIDX_REQ && reg_wdata[0]) tx_req <= 1'b1;
         else if (clr_req) tx_req <= 1'b0;
      end
   end

   assign cfg_mode = (mode_q == 2'b01);
   assign op_mode  = (mode_q == 2'b10);

   always_comb begin
      case (reg_addr)
         RIDX_MODE: reg_rdata = {30'b0, mode_q};
         RIDX_BASE: reg_rdata = 32'(base_addr);
         RIDX_REQ:  reg_rdata = {31'b0, tx_req};
         default:   reg_rdata = {30'b0, cfg_mode, op_mode};
      endcase
   end
endmodule

// File: rtl/txd_unpack.sv
module txd_unpack #(
   parameter int CW         = 12,
   parameter bit BIG_ENDIAN = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [CW-1:0] count,
   input  logic          load,
   input  logic [31:0]   word,
   output logic          need_word,
   output logic          done,
   output logic          out_valid,
   output logic [7:0]    out_data,
   output logic          out_last,
   input  logic          out_ready
);
   logic [CW-1:0] remaining;
   logic [1:0]    lane;
   logic          have_word;
   logic [31:0]   word_q;
   logic          fire;

   assign fire      = have_word && out_ready;
   assign need_word = (remaining != '0) && !have_word;
   assign out_valid = have_word;
   assign out_last  = have_word && (remaining == CW'(1));
   assign done      = fire && (remaining == CW'(1));

   generate
      if (BIG_ENDIAN) begin : g_msb_first
         assign out_data = word_q[{~lane, 3'b000} +: 8];
      end else begin : g_lsb_first
         assign out_data = word_q[{lane, 3'b000} +: 8];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remaining <= '0;
         lane      <= '0;
         have_word <= 1'b0;
         word_q    <= '0;
      end else if (start) begin
         remaining <= count;
         lane      <= '0;
         have_word <= 1'b0;
      end else begin
         if (load) begin
            word_q    <= word;
            have_word <= 1'b1;
         end
         if (fire) begin
            remaining <= remaining - CW'(1);
            lane      <= lane + 2'd1;
            if (lane == 2'd3 || remaining == CW'(1)) have_word <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/txd_walker.sv
module txd_walker
   import txd_pkg::*;
#(
   parameter int AW         = 32,
   parameter int CW         = 12,
   parameter int BASE_ENTRY = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          op_mode,
   input  logic          cfg_mode,
   input  logic          tx_req,
   input  logic [AW-1:0] base_addr,
   output logic          clr_req,
   output logic          busy,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [31:0]   mem_wdata,
   input  logic          mem_gnt,
   input  logic [31:0]   mem_rdata,
   output logic          up_start,
   output logic [CW-1:0] up_count,
   input  logic          up_need,
   output logic          up_load,
   input  logic          up_done
);
   localparam logic [AW-1:0] HEAD_OFS = AW'(BASE_ENTRY * DESC_BYTES);
   localparam logic [AW-1:0] STEP_DSC = AW'(DESC_BYTES);
   localparam logic [AW-1:0] STEP_WRD = AW'(WORD_BYTES);

   walk_st_e      st;
   logic [AW-1:0] cur_addr, data_addr;
   logic [31:0]   ctrl_q, ptr_q;
   logic          head_ok, fire;
   logic [3:0]    kind;

   assign kind     = ctrl_q[31:28];
   assign up_count = ctrl_q[CW-1:0];
   assign busy     = (st != W_IDLE);

   always_comb begin
      mem_req = 1'b0;
      mem_addr = cur_addr;
      unique case (st)
         W_CTRL:  mem_req = op_mode;
         W_PTR:   begin mem_req = 1'b1; mem_addr = cur_addr + STEP_WRD; end
         W_DATA:  begin mem_req = up_need; mem_addr = data_addr; end
         W_WBACK: mem_req = 1'b1;
         default: mem_req = 1'b0;
      endcase
   end

   assign mem_we    = (st == W_WBACK);
   assign mem_wdata = {KIND_EMPTY, ctrl_q[27:0]};
   assign fire      = mem_req && mem_gnt;
   assign up_load   = (st == W_DATA) && fire;
   assign up_start  = (st == W_DECIDE) && (kind == KIND_FRAME) && (up_count != '0);
   assign clr_req   = ((st == W_CTRL) && !op_mode) ||
                      ((st == W_DECIDE) && kind != KIND_FRAME && kind != KIND_LINK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= W_IDLE;
         cur_addr  <= '0;
         data_addr <= '0;
         ctrl_q    <= '0;
         ptr_q     <= '0;
         head_ok   <= 1'b0;
      end else begin
         unique case (st)
            W_IDLE: if (tx_req && op_mode) begin
               if (!head_ok) cur_addr <= base_addr + HEAD_OFS;
               head_ok <= 1'b1;
               st      <= W_CTRL;
            end
            W_CTRL: begin
               if (!op_mode) st <= W_IDLE;
               else if (fire) begin
                  ctrl_q <= mem_rdata;
                  st     <= W_PTR;
               end
            end
            W_PTR: if (fire) begin
               ptr_q <= mem_rdata;
               st    <= W_DECIDE;
            end
            W_DECIDE: begin
               if (kind == KIND_FRAME) begin
                  data_addr <= ptr_q[AW-1:0];
                  st        <= (up_count == '0) ? W_WBACK : W_DATA;
               end else if (kind == KIND_LINK) begin
                  cur_addr <= ptr_q[AW-1:0];
                  st       <= W_CTRL;
               end else begin
                  st <= W_IDLE;
               end
            end
            W_DATA: begin
               if (fire) data_addr <= data_addr + STEP_WRD;
               if (up_done) st <= W_WBACK;
            end
            W_WBACK: if (fire) begin
               cur_addr <= cur_addr + STEP_DSC;
               st       <= W_CTRL;
            end
            default: st <= W_IDLE;
         endcase
         if (cfg_mode) head_ok <= 1'b0;
      end
   end
endmodule

// File: rtl/txdesc_dma.sv
module txdesc_dma #(
   parameter int AW         = 32,
   parameter int CW         = 12,
   parameter int BASE_ENTRY = 0,
   parameter bit BIG_ENDIAN = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic [1:0]    reg_addr,
   input  logic [31:0]   reg_wdata,
   output logic [31:0]   reg_rdata,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [31:0]   mem_wdata,
   input  logic          mem_gnt,
   input  logic [31:0]   mem_rdata,
   output logic          tx_valid,
   output logic [7:0]    tx_data,
   output logic          tx_last,
   input  logic          tx_ready
);
   generate
      if (AW < 8 || AW > 32) begin : g_bad_aw
         $error("txdesc_dma: AW must lie in 8..32");
      end
      if (CW < 1 || CW > 12) begin : g_bad_cw
         $error("txdesc_dma: CW must lie in 1..12");
      end
      if (BASE_ENTRY < 0 || BASE_ENTRY > 15) begin : g_bad_entry
         $error("txdesc_dma: BASE_ENTRY must lie in 0..15");
      end
   endgenerate

   logic          clr_req, cfg_mode, op_mode, tx_req, busy;
   logic [AW-1:0] base_addr;
   logic          up_start, up_need, up_load, up_done;
   logic [CW-1:0] up_count;

   txd_regs #(.AW(AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .clr_req(clr_req),
      .cfg_mode(cfg_mode), .op_mode(op_mode), .base_addr(base_addr),
      .tx_req(tx_req)
   );

   txd_walker #(.AW(AW), .CW(CW), .BASE_ENTRY(BASE_ENTRY)) u_walk (
      .clk(clk), .rst_n(rst_n), .op_mode(op_mode), .cfg_mode(cfg_mode),
      .tx_req(tx_req), .base_addr(base_addr), .clr_req(clr_req), .busy(busy),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
      .up_start(up_start), .up_count(up_count), .up_need(up_need),
      .up_load(up_load), .up_done(up_done)
   );

   txd_unpack #(.CW(CW), .BIG_ENDIAN(BIG_ENDIAN)) u_unpack (
      .clk(clk), .rst_n(rst_n), .start(up_start), .count(up_count),
      .load(up_load), .word(mem_rdata), .need_word(up_need), .done(up_done),
      .out_valid(tx_valid), .out_data(tx_data), .out_last(tx_last),
      .out_ready(tx_ready)
   );
endmodule

// File: rtl/txdesc_dma_chk.sv
module txdesc_dma_chk #(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mem_req,
   input logic          mem_gnt,
   input logic          mem_we,
   input logic [AW-1:0] mem_addr,
   input logic [31:0]   mem_wdata,
   input logic          tx_valid,
   input logic          tx_ready,
   input logic [7:0]    tx_data,
   input logic          tx_last,
   input logic          tx_req,
   input logic          busy,
   input logic          op_mode
);
   AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R9

   AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last)); // R10

   AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      tx_last |-> tx_valid); // R4

   AST_NO_START_OUTSIDE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && !op_mode |=> !busy); // R2

   AST_REQ_DROPS_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_req) |-> !busy); // R8
endmodule

bind txdesc_dma txdesc_dma_chk #(.AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_gnt(mem_gnt),
   .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
   .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
   .tx_last(tx_last), .tx_req(tx_req), .busy(busy), .op_mode(op_mode)
);

// File: tb/txdesc_dma_tb.sv
module txdesc_dma_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic        mem_gnt = 1'b0;
   logic        tx_valid, tx_last;
   logic [7:0]  tx_data;
   logic        tx_ready = 1'b0;

   always #10 clk = ~clk;

   txdesc_dma u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
      .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready)
   );

   logic [31:0] mem [0:255];
   logic [8:0]  exp_q [$];
   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int req_seen = 0;
   int rx_bytes = 0;

   assign mem_rdata = mem[mem_addr[9:2]];

   // memory model and stream monitor, both act away from the clock edge
   always @(negedge clk) begin
      logic [8:0] e;
      cyc = cyc + 1;
      mem_gnt  = (cyc % 3) != 1;
      tx_ready = (cyc % 5) != 2;
      if (rst_n && mem_req) req_seen = req_seen + 1;
      if (rst_n && mem_req && mem_gnt && mem_we) mem[mem_addr[9:2]] = mem_wdata;
      if (rst_n && tx_valid && tx_ready) begin
         rx_bytes = rx_bytes + 1;
         checks = checks + 1;
         if (exp_q.size() == 0) begin
            errors = errors + 1;
            $display("FAIL R4 unexpected byte: actual %h last %0d expected none", tx_data, tx_last);
         end else begin
            e = exp_q.pop_front();
            if (e !== {tx_last, tx_data}) begin
               errors = errors + 1;
               $display("FAIL R4 stream byte: actual %h expected %h", {tx_last, tx_data}, e);
            end
         end
      end
   end

   task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         errors = errors + 1;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] v);
      @(negedge clk);
      reg_addr = a;
      #1 v = reg_rdata;
   endtask

   task automatic set_desc(input int addr, input logic [31:0] ctl, input logic [31:0] ptr);
      mem[addr >> 2]     = ctl;
      mem[(addr >> 2) + 1] = ptr;
   endtask

   // scoreboard driver: queue the bytes a frame must produce
   task automatic push_frame(input int ptr, input int len);
      for (int i = 0; i < len; i++) begin
         int a;
         logic [31:0] w;
         a = ptr + i;
         w = mem[a >> 2];
         exp_q.push_back({(i == len - 1), w[8 * (a & 3) +: 8]});
      end
   endtask

   task automatic wait_idle(input string tag);
      logic [31:0] v;
      v = 32'd1;
      for (int i = 0; i < 5000; i++) begin
         rd(2'd2, v);
         if (v[0] == 1'b0) break;
      end
      check_eq(tag, v, 32'd0);
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors = errors + 1;
      $display("FAIL R8 watchdog: actual running expected idle");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] v;
      for (int k = 0; k < 256; k++)
         mem[k] = (k >= 128) ? (32'h0101_0101 * k + 32'h0403_0201) : 32'h0;
      for (int k = 0; k < 16; k++) set_desc(32'h40 + 8 * k, 32'hA000_0000, 32'h0);
      set_desc(32'h40, 32'h9000_0000, 32'h100);          // queue head entry: link
      set_desc(32'h100, 32'h7000_0005, 32'h200);
      set_desc(32'h108, 32'h7000_0000, 32'h240);
      set_desc(32'h110, 32'h7000_0008, 32'h280);
      set_desc(32'h118, 32'h3000_0077, 32'h0);
      set_desc(32'h128, 32'h7000_0004, 32'h340);         // trap: reached only if a link is ignored

      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_eq("R1 tx_valid after reset", {31'b0, tx_valid}, 32'd0);
      check_eq("R1 mem_req after reset", {31'b0, mem_req}, 32'd0);
      rd(2'd3, v); check_eq("R1 status after reset", v, 32'd0);
      rd(2'd2, v); check_eq("R1 request after reset", v, 32'd0);
      rd(2'd0, v); check_eq("R1 mode after reset", v, 32'd0);

      wr(2'd0, 32'h1);
      rd(2'd3, v); check_eq("R2 status in config", v, 32'h2);
      wr(2'd1, 32'h40);
      wr(2'd2, 32'h1);
      repeat (40) @(negedge clk);
      check_eq("R2 no access outside running mode", req_seen, 32'd0);
      rd(2'd2, v); check_eq("R2 request held outside running mode", v, 32'd1);
      wr(2'd2, 32'h0);
      rd(2'd2, v); check_eq("R8 writing zero leaves request", v, 32'd1);

      // round 1: head via table, frames of 5, 0, 8 bytes, stop on empty
      push_frame(32'h200, 5);
      push_frame(32'h280, 8);
      wr(2'd0, 32'h2);
      rd(2'd3, v); check_eq("R2 status in running mode", v, 32'h1);
      wait_idle("R8 request cleared after round 1");
      check_eq("R4 round 1 all bytes seen", exp_q.size(), 32'd0);
      check_eq("R5 zero count sends nothing", rx_bytes, 32'd13);
      check_eq("R7 frame 0 written back", mem[32'h100 >> 2], 32'h3000_0005);
      check_eq("R7 pointer word untouched", mem[32'h104 >> 2], 32'h200);
      check_eq("R5 zero count written back", mem[32'h108 >> 2], 32'h3000_0000);
      check_eq("R7 frame 2 written back", mem[32'h110 >> 2], 32'h3000_0008);
      check_eq("R3 head table entry not written", mem[32'h40 >> 2], 32'h9000_0000);

      // round 2: resume at stopped entry, link back to ring start
      set_desc(32'h118, 32'h7000_0003, 32'h2C0);
      set_desc(32'h120, 32'h9000_0000, 32'h100);
      push_frame(32'h2C0, 3);
      wr(2'd2, 32'h1);
      wait_idle("R8 request cleared after round 2");
      check_eq("R8 resumed at stopped entry", mem[32'h118 >> 2], 32'h3000_0003);
      check_eq("R6 round 2 bytes seen", exp_q.size(), 32'd0);
      check_eq("R6 link entry not written", mem[32'h120 >> 2], 32'h9000_0000);

      // round 3: link target must be where engine stopped; end-of-set stops
      set_desc(32'h100, 32'h7000_0001, 32'h300);
      set_desc(32'h108, 32'hA000_0042, 32'h0);
      push_frame(32'h300, 1);
      wr(2'd2, 32'h1);
      wait_idle("R8 request cleared after round 3");
      check_eq("R6 jump target used", mem[32'h100 >> 2], 32'h3000_0001);
      check_eq("R8 end entry not written", mem[32'h108 >> 2], 32'hA000_0042);
      check_eq("R6 round 3 bytes seen", exp_q.size(), 32'd0);

      // round 4: resume at the end-of-set entry once it becomes a frame
      set_desc(32'h108, 32'h7000_0002, 32'h308);
      push_frame(32'h308, 2);
      wr(2'd2, 32'h1);
      wait_idle("R8 request cleared after round 4");
      check_eq("R8 resumed at end entry", mem[32'h108 >> 2], 32'h3000_0002);
      check_eq("R4 round 4 bytes seen", exp_q.size(), 32'd0);
      check_eq("R4 total byte count", rx_bytes, 32'd19);
      check_eq("R1 stream idle at end", {31'b0, tx_valid}, 32'd0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule